// File: doc/BRIEF.md
# Fixed Interrupt Priority Arbiter

This block collects fixed-mode interrupt vectors for one processor core, holds them until the core can take them, and tracks which of them the core is servicing. A 256-bit pending register gets one bit per accepted vector. A 256-bit in-service register gets one bit per vector handed to the core. A read-only priority value is formed from a task-priority byte that software writes and from the highest vector now in service. A vector is handed to the core only if its class (the upper four bits of the vector) is strictly above the class of that priority value.

The block is driven by a two-state machine. In `S_ARB` it waits for the core to signal ready while an eligible vector is pending. The transition `S_ARB -> S_HAND` (grant) happens at the clock edge where ready and eligibility coincide. On that edge the highest pending bit moves to the in-service register and the vector is latched. `S_HAND` drives the dispatch strobe for exactly one cycle, and the transition `S_HAND -> S_ARB` (release) is unconditional. An end-of-interrupt strobe may arrive in either state. It retires the highest in-service bit, after which arbitration continues with the remaining pending vectors. Non-fixed delivery modes and bus address decoding sit outside the block.

Top module: `fipa_top`

## Requirements
- R1: After reset, the pending and in-service registers are all zero, the priority value reads 0 and no dispatch is signalled.
- R2: An accept of vector v with v >= 16 sets pending bit v at the next clock edge. An accept for a vector whose bit is already set leaves one bit set.
- R3: Accepts of vectors 0 to 15 are dropped and change no pending bit.
- R4: The priority value is 32 bits wide, with bits 31:8 always zero. Its class (bits 7:4) is the larger of the task-priority class and the class of the highest in-service vector, where an empty in-service register counts as vector 0.
- R5: The priority sub-class (bits 3:0) equals task-priority bits 3:0 when the task class is greater than or equal to the in-service class, and is 0 when the task class is smaller.
- R6: The highest pending vector is granted only if its class is strictly greater than the priority class. A class of 15 blocks all vectors, and the sub-class plays no part in the decision.
- R7: A grant at the edge where core ready is high moves the highest pending bit to the in-service register. During the following cycle, dispatch valid is high for exactly one cycle with that vector. Core ready is ignored in that cycle.
- R8: An end-of-interrupt clears only the highest set in-service bit. With the in-service register empty it changes nothing.
- R9: If an accept and a grant name the same vector at the same edge, that pending bit stays set while the in-service bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Accept strobe for a fixed interrupt |
| acc_vec | input | 8 | Vector being accepted |
| core_rdy | input | 1 | Core can take a new interrupt |
| dsp_valid | output | 1 | One-cycle dispatch strobe |
| dsp_vec | output | 8 | Dispatched vector, valid with dsp_valid |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task-priority write enable |
| tpr_wdata | input | 8 | Task-priority write data |
| ppr_rd | output | 32 | Processor-priority value |
| irr_rd | output | 256 | Pending-request register |
| isr_rd | output | 256 | In-service register |

## Verification
The bench goes after several corner cases:
- A pending vector whose class equals the priority class. A design that compares with greater-or-equal would dispatch it.
- Equal task and in-service classes, where a design would return the wrong sub-class.
- A sub-class that differs from the pending vector's low bits. A design that compared full bytes would block or grant the wrong vector.
- End-of-interrupt with two vectors in service, and with none. A design that cleared the lowest bit or all bits would show a wrong priority class afterwards.
- An accept and a grant of the same vector at the same edge. A design with clear-over-set ordering would lose that request.

// File: rtl/fipa_pkg.sv
package fipa_pkg;
    typedef enum logic [0:0] {
        S_ARB  = 1'b0,
        S_HAND = 1'b1
    } fipa_state_e;
endpackage

// File: rtl/fipa_hi_find.sv
// Highest-set-bit finder over a parameterised vector.
module fipa_hi_find #(
    parameter int N = 256,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |bits;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/fipa_ppr.sv
// Processor-priority value from task priority and top in-service vector.
module fipa_ppr #(
    parameter int VEC_W = 8,
    parameter int SUB_W = 4,
    parameter int REG_W = 32,
    localparam int CLS_W = VEC_W - SUB_W
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic [VEC_W-1:0] isrv,
    output logic [REG_W-1:0] ppr
);
    logic [CLS_W-1:0] t_cls, i_cls, cls;
    logic [SUB_W-1:0] sub;
    logic             task_wins;

    always_comb begin
        t_cls     = tpr[VEC_W-1:SUB_W];
        i_cls     = isrv[VEC_W-1:SUB_W];
        task_wins = (t_cls >= i_cls);
        cls       = task_wins ? t_cls : i_cls;
        sub       = task_wins ? tpr[SUB_W-1:0] : '0;
        ppr       = REG_W'({cls, sub});
    end
endmodule

// File: rtl/fipa_top.sv
module fipa_top #(
    parameter int NUM_VEC  = 256,
    parameter int RSVD_VEC = 16,
    parameter int SUB_W    = 4,
    parameter int REG_W    = 32,
    localparam int VEC_W   = $clog2(NUM_VEC),
    localparam int CLS_W   = VEC_W - SUB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [VEC_W-1:0]   acc_vec,
    input  logic               core_rdy,
    output logic               dsp_valid,
    output logic [VEC_W-1:0]   dsp_vec,
    input  logic               eoi,
    input  logic               tpr_we,
    input  logic [VEC_W-1:0]   tpr_wdata,
    output logic [REG_W-1:0]   ppr_rd,
    output logic [NUM_VEC-1:0] irr_rd,
    output logic [NUM_VEC-1:0] isr_rd
);
    import fipa_pkg::*;

    fipa_state_e        state_q, state_n;
    logic [NUM_VEC-1:0] irr_q, isr_q, irr_n, isr_n;
    logic [NUM_VEC-1:0] acc_set, grant_mask, eoi_mask;
    logic [VEC_W-1:0]   tpr_q, dsp_vec_q;
    logic [VEC_W-1:0]   irr_idx, isr_idx, isrv;
    logic               irr_any, isr_any;
    logic [REG_W-1:0]   ppr_w;
    logic [CLS_W-1:0]   irr_cls, ppr_cls;
    logic               eligible, grant, acc_ok;

    fipa_hi_find #(.N(NUM_VEC)) u_irr_find (
        .bits (irr_q),
        .any  (irr_any),
        .idx  (irr_idx)
    );

    fipa_hi_find #(.N(NUM_VEC)) u_isr_find (
        .bits (isr_q),
        .any  (isr_any),
        .idx  (isr_idx)
    );

    assign isrv = isr_any ? isr_idx : '0;

    fipa_ppr #(.VEC_W(VEC_W), .SUB_W(SUB_W), .REG_W(REG_W)) u_ppr (
        .tpr  (tpr_q),
        .isrv (isrv),
        .ppr  (ppr_w)
    );

    // Arbitration: class-only comparison against the priority class
    always_comb begin
        irr_cls  = irr_idx[VEC_W-1:SUB_W];
        ppr_cls  = ppr_w[VEC_W-1:SUB_W];
        eligible = irr_any && (irr_cls > ppr_cls);
        grant    = (state_q == S_ARB) && core_rdy && eligible;
        acc_ok   = acc_valid && (acc_vec >= VEC_W'(RSVD_VEC));
    end

    // Register update masks; accept is applied after grant clear
    always_comb begin
        acc_set    = acc_ok ? (NUM_VEC'(1) << acc_vec) : '0;
        grant_mask = grant ? (NUM_VEC'(1) << irr_idx) : '0;
        eoi_mask   = (eoi && isr_any) ? (NUM_VEC'(1) << isr_idx) : '0;
        irr_n      = (irr_q & ~grant_mask) | acc_set;
        isr_n      = (isr_q & ~eoi_mask) | grant_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q     <= '0;
            isr_q     <= '0;
            tpr_q     <= '0;
            dsp_vec_q <= '0;
        end else begin
            irr_q <= irr_n;
            isr_q <= isr_n;
            if (tpr_we) tpr_q <= tpr_wdata;
            if (grant) dsp_vec_q <= irr_idx;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_ARB;
        else        state_q <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_ARB:  if (grant) state_n = S_HAND;
            S_HAND: state_n = S_ARB;
            default: state_n = S_ARB;
        endcase
    end

    // Outputs
    always_comb begin
        dsp_valid = (state_q == S_HAND);
        dsp_vec   = dsp_vec_q;
        ppr_rd    = ppr_w;
        irr_rd    = irr_q;
        isr_rd    = isr_q;
    end

    p_acc_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_vec >= VEC_W'(RSVD_VEC)) |=> irr_q[$past(acc_vec)]);

    p_rsvd_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irr_q[RSVD_VEC-1:0] == '0) && (isr_q[RSVD_VEC-1:0] == '0));

    p_disp_beats_ppr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid |-> (dsp_vec[VEC_W-1:SUB_W] > $past(ppr_cls)));

    p_hand_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid |=> !dsp_valid);

    p_disp_in_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid |-> isr_q[dsp_vec]);

    p_eoi_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !isr_any && !grant) |=> (isr_q == '0));

    p_same_vec_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && acc_valid && acc_vec == irr_idx) |=> (irr_q[$past(irr_idx)] && isr_q[$past(irr_idx)]));
endmodule

// File: tb/fipa_top_tb.sv
module fipa_top_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acc_valid = 1'b0;
    logic [7:0]   acc_vec = '0;
    logic         core_rdy = 1'b0;
    logic         dsp_valid;
    logic [7:0]   dsp_vec;
    logic         eoi = 1'b0;
    logic         tpr_we = 1'b0;
    logic [7:0]   tpr_wdata = '0;
    logic [31:0]  ppr_rd;
    logic [255:0] irr_rd, isr_rd;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fipa_top u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vec(acc_vec),
        .core_rdy(core_rdy), .dsp_valid(dsp_valid), .dsp_vec(dsp_vec), .eoi(eoi),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .ppr_rd(ppr_rd),
        .irr_rd(irr_rd), .isr_rd(isr_rd)
    );

    function automatic logic [255:0] bitv(input int v);
        return 256'(1) << v;
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic accept(input logic [7:0] v);
        @(negedge clk); acc_valid = 1'b1; acc_vec = v;
        @(negedge clk); acc_valid = 1'b0;
    endtask

    task automatic write_tpr(input logic [7:0] v);
        @(negedge clk); tpr_we = 1'b1; tpr_wdata = v;
        @(negedge clk); tpr_we = 1'b0;
    endtask

    task automatic pulse_eoi;
        @(negedge clk); eoi = 1'b1;
        @(negedge clk); eoi = 1'b0;
    endtask

    // Ready for one cycle; then dsp_valid is observed in the following cycle
    task automatic try_dispatch(input string req, input bit exp_go, input logic [7:0] exp_v);
        @(negedge clk); core_rdy = 1'b1;
        @(negedge clk); core_rdy = 1'b0;
        chk(req, 256'(dsp_valid), 256'(exp_go));
        if (exp_go) chk(req, 256'(dsp_vec), 256'(exp_v));
        @(negedge clk);
        chk(req, 256'(dsp_valid), 256'(0));
    endtask

    task automatic t_reset;
        chk("R1", irr_rd, '0);
        chk("R1", isr_rd, '0);
        chk("R1", 256'(ppr_rd), '0);
        chk("R1", 256'(dsp_valid), '0);
    endtask

    task automatic t_accept;
        accept(8'h35);
        accept(8'h35);
        chk("R2", irr_rd, bitv(8'h35));
        accept(8'h0F);
        accept(8'h00);
        chk("R3", irr_rd, bitv(8'h35));
    endtask

    task automatic t_dispatch_eoi;
        try_dispatch("R7", 1'b1, 8'h35);
        chk("R7", irr_rd, '0);
        chk("R7", isr_rd, bitv(8'h35));
        chk("R4", 256'(ppr_rd), 256'(32'h30));
        accept(8'h32);
        try_dispatch("R6", 1'b0, 8'h00);   // class 3 not above class 3
        accept(8'h41);
        try_dispatch("R7", 1'b1, 8'h41);
        chk("R4", 256'(ppr_rd), 256'(32'h40));
        pulse_eoi();
        chk("R8", isr_rd, bitv(8'h35));
        chk("R8", 256'(ppr_rd), 256'(32'h30));
        pulse_eoi();
        chk("R8", isr_rd, '0);
        chk("R4", 256'(ppr_rd), '0);
        try_dispatch("R6", 1'b1, 8'h32);
        pulse_eoi();
        pulse_eoi();
        chk("R8", isr_rd, '0);
        chk("R8", irr_rd, '0);
    endtask

    task automatic t_task_prio;
        write_tpr(8'h5A);
        chk("R5", 256'(ppr_rd), 256'(32'h5A));
        accept(8'h5F);
        try_dispatch("R6", 1'b0, 8'h00);   // sub-class A below F yet blocked
        write_tpr(8'h4F);
        try_dispatch("R6", 1'b1, 8'h5F);
        chk("R5", 256'(ppr_rd), 256'(32'h50));
        write_tpr(8'h5C);
        chk("R5", 256'(ppr_rd), 256'(32'h5C));
        write_tpr(8'hF0);
        chk("R4", 256'(ppr_rd), 256'(32'hF0));
        accept(8'hFF);
        try_dispatch("R6", 1'b0, 8'h00);
        pulse_eoi();
        write_tpr(8'h00);
        try_dispatch("R6", 1'b1, 8'hFF);
        pulse_eoi();
        chk("R8", isr_rd, '0);
    endtask

    task automatic t_same_vec;
        accept(8'h70);
        @(negedge clk); acc_valid = 1'b1; acc_vec = 8'h70; core_rdy = 1'b1;
        @(negedge clk); acc_valid = 1'b0; core_rdy = 1'b0;
        chk("R9", 256'(dsp_vec), 256'(8'h70));
        chk("R9", irr_rd, bitv(8'h70));
        chk("R9", isr_rd, bitv(8'h70));
        pulse_eoi();
        try_dispatch("R9", 1'b1, 8'h70);
        pulse_eoi();
        chk("R9", irr_rd, '0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_accept();
        t_dispatch_eoi();
        t_task_prio();
        t_same_vec();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule